// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is an SPI target for use inside a logic device. A microcontroller master sends it fixed 16-bit words, each with chip select held low for the whole word. SCK idles low and data is taken on the rising edge. Every word carries a 4-bit opcode in its upper bits and a 12-bit operand in its lower bits. When a complete word arrives, the block presents the opcode and operand with a one-cycle strobe for the logic downstream.

One opcode is reserved for configuration. A word carrying it loads the low byte of the operand into a persistent mode register, which the rest of the device reads to choose its operating mode. The three SPI pins are asynchronous to the system clock. They are brought into the system clock domain through a synchronizer, and all edge detection happens there. For this to work, SCK must run at no more than one sixth of the system clock.

Top module: `spi_cmd_rx`

## Requirements
- R1: A word is 16 bits sent most significant bit first. Bits 15..12 appear on `cmd_code` and bits 11..0 appear on `cmd_data`.
- R2: MOSI is sampled on each rising edge of SCK (SCK idles low). A MOSI change while SCK is low and before the next rising edge does not alter the captured bit.
- R3: A frame is the span during which `cs_n` is low. It is judged when `cs_n` rises, and it is accepted only if exactly 16 rising SCK edges arrived in that span.
- R4: A frame with fewer than 16 bits is discarded. `cmd_valid` stays low, and `cmd_code`, `cmd_data` and `mode_reg` keep their values.
- R5: A frame with more than 16 bits is discarded in the same way.
- R6: Each accepted word raises `cmd_valid` for exactly one system clock cycle, and it does so within 10 cycles of `cs_n` rising.
- R7: An accepted word whose opcode equals `CFG_OPCODE` (default 4'h1) loads `cmd_data[7:0]` into `mode_reg`. Words with any other opcode leave `mode_reg` unchanged.
- R8: Reset (synchronous, active low) clears `mode_reg`, `cmd_code`, `cmd_data` and `cmd_valid` to zero. It also abandons any partly received frame, so bits sent before reset never count toward a word.
- R9: Rising SCK edges while `cs_n` is high are ignored. A following well-formed frame is decoded exactly as sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI serial clock from the master, idle low |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low chip select framing one word |
| cmd_valid | output | 1 | One-cycle strobe for an accepted word |
| cmd_code | output | 4 | Opcode of the last accepted word |
| cmd_data | output | 12 | Operand of the last accepted word |
| mode_reg | output | 8 | Persistent mode register |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a frame while chip select stays low. Here the receiver must drop the bits already counted without seeing a chip-select edge. The bench sends half a word, pulses reset, sends the remaining half, and expects the frame to be rejected. Discarding by bit count is reached with 15-bit and 17-bit frames. Stray SCK pulses are sent with chip select high just before a valid word.

// File: rtl/spi_cmd_pkg.sv
// Shared widths and the decoded word layout for the SPI command receiver.
// Assumes a fixed opcode-over-operand split; downstream logic relies on it.
package spi_cmd_pkg;
    localparam int WORD_W = 16;
    localparam int CMD_W  = 4;
    localparam int DATA_W = WORD_W - CMD_W;

    typedef struct packed {
        logic [CMD_W-1:0]  code;
        logic [DATA_W-1:0] data;
    } cmd_word_t;
endpackage

// File: rtl/spi_cmd_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes each bit is sampled independently; STAGES must be at least 2.
module spi_cmd_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the inputs through the flop chain, reset to the idle value.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_cmd_shifter.sv
// Frames and shifts serial bits in the system clock domain.
// Assumes synchronized inputs and SCK no faster than clk/6, so each
// SCK level lasts several clk cycles and MOSI is stable at the rising edge.
module spi_cmd_shifter
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              cs_n_s,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic              sck_q, cs_q;
    logic              sck_rise, cs_rise;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;

    assign sck_rise = sck_s & ~sck_q;
    assign cs_rise  = cs_n_s & ~cs_q;

    // Remember the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
        end
    end

    // Shift bits during a frame and judge the bit count when it closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            word_valid <= 1'b0;
            if (cs_rise) begin
                if (bit_cnt == CNT_W'(WORD_W)) begin
                    word_valid <= 1'b1;
                    word       <= shreg;
                end
                bit_cnt <= '0;
            end else if (cs_n_s) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[WORD_W-2:0], mosi_s};
                if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(CNT_MAX)); // R5
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && cs_q) |=> (bit_cnt == '0)); // R9
    AST_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (bit_cnt == '0 && cs_q)); // R3
endmodule

// File: rtl/spi_cmd_decode.sv
// Splits an accepted word into opcode and operand and keeps the mode register.
// Assumes word_valid is a single-cycle pulse from the framing logic.
module spi_cmd_decode
    import spi_cmd_pkg::*;
#(
    parameter logic [CMD_W-1:0] CFG_OPCODE = 4'h1,
    parameter int               MODE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_code,
    output logic [DATA_W-1:0] cmd_data,
    output logic [MODE_W-1:0] mode_reg
);
    cmd_word_t fields;
    assign fields = cmd_word_t'(word);

    // Register the decoded fields and update the mode on the config opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
            cmd_data  <= '0;
            mode_reg  <= '0;
        end else begin
            cmd_valid <= word_valid;
            if (word_valid) begin
                cmd_code <= fields.code;
                cmd_data <= fields.data;
                if (fields.code == CFG_OPCODE) mode_reg <= fields.data[MODE_W-1:0];
            end
        end
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R6
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> ($stable(cmd_code) && $stable(cmd_data))); // R4
endmodule

// File: rtl/spi_cmd_rx.sv
// SPI target receiving 16-bit opcode/operand words framed by chip select.
// Assumes SCK idles low, data taken on the rising edge, SCK <= clk/6.
module spi_cmd_rx
    import spi_cmd_pkg::*;
#(
    parameter logic [3:0] CFG_OPCODE  = 4'h1,
    parameter int         MODE_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              cmd_valid,
    output logic [3:0]        cmd_code,
    output logic [11:0]       cmd_data,
    output logic [MODE_W-1:0] mode_reg
);
    logic [2:0]        pins_s;
    logic              word_valid;
    logic [WORD_W-1:0] word;

    spi_cmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, mosi, sck}),
        .dout (pins_s)
    );

    spi_cmd_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[0]),
        .mosi_s    (pins_s[1]),
        .cs_n_s    (pins_s[2]),
        .word_valid(word_valid),
        .word      (word)
    );

    spi_cmd_decode #(.CFG_OPCODE(CFG_OPCODE), .MODE_W(MODE_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_valid(word_valid),
        .word      (word),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_data  (cmd_data),
        .mode_reg  (mode_reg)
    );

    AST_MODE_ONLY_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_reg != $past(mode_reg)) |-> (cmd_valid && cmd_code == CFG_OPCODE)); // R7
endmodule

// File: tb/spi_cmd_rx_bench.sv
module spi_cmd_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4 * CLK_PERIOD;
    localparam int NVEC       = 7;
    localparam logic [15:0] VEC [NVEC] = '{
        16'h10A5, 16'h2ABC, 16'hFFFF, 16'h1F3C, 16'h0000, 16'h8001, 16'h1C00
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        cs_n = 1'b1;
    logic        cmd_valid;
    logic [3:0]  cmd_code;
    logic [11:0] cmd_data;
    logic [7:0]  mode_reg;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mode = 8'h00;
    int pulses;
    int width;
    logic [3:0]  got_code;
    logic [11:0] got_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_rx u_spi_cmd_rx (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data),
        .mode_reg(mode_reg)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send n bits MSB first; MOSI changes while SCK is low, with a glitch mid-low.
    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = ~w[i];
            #(HALF_SCK/2);
            mosi = w[i];
            #(HALF_SCK/2);
            sck = 1'b1;
            #HALF_SCK;
            sck = 1'b0;
        end
    endtask

    task automatic frame(input logic [31:0] w, input int n);
        cs_n = 1'b0;
        #HALF_SCK;
        send_bits(w, n);
        #HALF_SCK;
        cs_n = 1'b1;
    endtask

    // Watch cmd_valid for 12 cycles after cs_n rises.
    task automatic watch();
        pulses = 0; width = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (cmd_valid) begin
                width++;
                if (width == 1) pulses++;
                got_code = cmd_code;
                got_data = cmd_data;
            end else width = 0;
        end
        #(HALF_SCK);
    endtask

    initial begin
        #(2_000_000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(cmd_valid == 0 && mode_reg == 0 && cmd_code == 0 && cmd_data == 0,
              "R8 reset state", {mode_reg, cmd_code, cmd_data}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk: R1 fields, R2 sampling, R3 framing, R6 strobe, R7 mode.
        for (int v = 0; v < NVEC; v++) begin
            frame({16'h0, VEC[v]}, 16);
            watch();
            if (VEC[v][15:12] == 4'h1) exp_mode = VEC[v][7:0];
            check(pulses == 1, "R6 one pulse per word", pulses, 1);
            check(got_code == VEC[v][15:12] && got_data == VEC[v][11:0],
                  "R1 R2 fields", {got_code, got_data}, VEC[v]);
            check(mode_reg == exp_mode, "R7 mode register", mode_reg, exp_mode);
        end

        // R4: short frame (15 bits) discarded, outputs held.
        frame(32'h1234, 15);
        watch();
        check(pulses == 0, "R4 short frame no strobe", pulses, 0);
        check(cmd_code == 4'h1 && cmd_data == 12'hC00 && mode_reg == exp_mode,
              "R4 short frame outputs held", {mode_reg, cmd_code, cmd_data},
              {exp_mode, 16'h1C00});

        // R5: long frame (17 bits) discarded.
        frame(32'h1_10EE, 17);
        watch();
        check(pulses == 0, "R5 long frame no strobe", pulses, 0);
        check(mode_reg == exp_mode, "R5 long frame mode held", mode_reg, exp_mode);

        // R9: SCK pulses with cs_n high, then a config word.
        mosi = 1'b1;
        for (int k = 0; k < 5; k++) begin
            #HALF_SCK sck = 1'b1;
            #HALF_SCK sck = 1'b0;
        end
        frame(32'h0000_1077, 16);
        watch();
        exp_mode = 8'h77;
        check(pulses == 1 && got_code == 4'h1 && got_data == 12'h077,
              "R9 stray SCK ignored", {got_code, got_data}, 16'h1077);
        check(mode_reg == exp_mode, "R9 R7 mode after stray SCK", mode_reg, exp_mode);

        // R8: reset mid-frame; the remaining 8 bits alone must be rejected.
        cs_n = 1'b0;
        #HALF_SCK;
        send_bits(32'h10, 8);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(mode_reg == 0 && cmd_code == 0 && cmd_data == 0, "R8 reset clears",
              {mode_reg, cmd_code, cmd_data}, 0);
        rst_n = 1'b1;
        exp_mode = 8'h00;
        send_bits(32'h55, 8);
        #HALF_SCK;
        cs_n = 1'b1;
        watch();
        check(pulses == 0, "R8 partial frame abandoned", pulses, 0);
        check(mode_reg == 0, "R8 mode after abandoned frame", mode_reg, 0);

        // R7: non-config opcode leaves mode; config opcode sets it again.
        frame(32'h0000_13C9, 16);
        watch();
        exp_mode = 8'hC9;
        check(mode_reg == exp_mode, "R7 config after reset", mode_reg, exp_mode);
        frame(32'h0000_3011, 16);
        watch();
        check(pulses == 1 && mode_reg == exp_mode, "R7 other opcode keeps mode",
              mode_reg, exp_mode);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule